// File: doc/BRIEF.md
# Endpoint-Zero Control Transfer Stage and Interrupt Logic

This block follows the stages of a USB control transfer on endpoint zero and
holds the small register set that firmware uses to steer it. It receives
decoded token strobes (SETUP, IN, OUT), the data direction and the "no data
stage" indication sampled with the SETUP token, and strobes from the buffer
logic and the error detector. From these it keeps five sticky interrupt flags,
raises one combined interrupt request, and tells the packet layer whether the
status stage is answered with ACK or a zero-length packet, or with NAK.

Firmware holds the status stage off until it has finished the request. It does
this by leaving a completion-enable bit at 0, which every SETUP token forces
back to 0. While the bit is 0, a token that reverses the data-stage direction
raises a stage-transition interrupt, so firmware learns that the host has
moved on. Writing the bit to 1 lets the next status token complete the
transfer, as long as the response-mode field selects handshake control
(binary 01).

Every pin is a plain level or a single-cycle strobe. There is no streaming
data path, so no valid/ready handshake and no back-pressure. Tokens come one
at a time; if strobes overlap, SETUP takes priority. Register reads are
combinational.

Top module: `ep0_ctrl_xfer`

## Requirements
- R1: After reset both registers read 0x00, `irq_o` is low and `status_ack_o` is low.
- R2: The control register (`cpu_sel_i`=0) stores bit 0 (completion enable) from a write. Bits 7:1 ignore writes and always read 0.
- R3: `status_ack_o` is 1 exactly when the completion enable is 1 and `rsp_mode_i` equals 2'b01. Otherwise the status stage is answered with NAK (0).
- R4: A SETUP token clears the completion enable. This takes priority over a CPU write in the same cycle.
- R5: The flag register (`cpu_sel_i`=1) holds buffer-ready in bit 0, transfer-done in bit 1, stage-transition in bit 2, SETUP-buffer-ready in bit 3 and error in bit 4. `buf_rdy_i` sets bit 0 and `setup_buf_rdy_i` sets bit 3. Bits 7:5 always read 0.
- R6: Writing 0 to a flag bit clears it. Writing 1 leaves it unchanged. A hardware set in the same cycle as a clearing write wins.
- R7: In a data stage, or in the status stage, a token in the status direction (IN for control write and no-data transfers, OUT for control read) completes the transfer when `status_ack_o` is 1. Completion sets bit 1 and returns the tracker to idle. In idle, IN and OUT tokens change nothing.
- R8: With completion enable 0, an IN token during the OUT data stage of a control write, or an OUT token during the IN data stage of a control read, sets bit 2.
- R9: A no-data transfer never sets bit 2. Its first IN token after SETUP is the status token.
- R10: `xfer_err_i` sets bit 4. A SETUP token clears bit 4 unless an error strobe arrives in the same cycle.
- R11: `irq_o` is high exactly when at least one of the five flags is 1.
- R12: A status-direction token answered with NAK leaves the tracker in the status stage. A later status token completes the transfer once `status_ack_o` is 1. With completion enable 1 and any mode other than 01, the reversal token sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tok_setup_i | input | 1 | SETUP token strobe |
| tok_in_i | input | 1 | IN token strobe |
| tok_out_i | input | 1 | OUT token strobe |
| setup_rd_i | input | 1 | Sampled with SETUP: 1 = control read (IN data stage) |
| setup_nodata_i | input | 1 | Sampled with SETUP: 1 = no data stage |
| buf_rdy_i | input | 1 | Endpoint buffer became accessible |
| setup_buf_rdy_i | input | 1 | SETUP buffer became readable |
| xfer_err_i | input | 1 | Control transfer error strobe |
| rsp_mode_i | input | 2 | Response mode; 2'b01 enables handshake control |
| cpu_we_i | input | 1 | Register write strobe |
| cpu_sel_i | input | 1 | Register select: 0 control, 1 flags |
| cpu_wdata_i | input | 8 | Register write data |
| cpu_rdata_o | output | 8 | Read data of the selected register |
| status_ack_o | output | 1 | Status handshake: 1 ACK/zero-length, 0 NAK |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Flag and enable changes appear one rising edge after the strobe or write that
causes them. `status_ack_o`, `irq_o` and read data then follow at once,
because they are combinational from the registers and `rsp_mode_i`. The bench
drives every strobe at a falling edge and drops it at the next falling edge.
It reads results a nanosecond after that second falling edge, which is after
exactly one rising edge. The sweep covers every transfer kind with every
enable and mode value. Each run then goes through either the idle path after
completion or the NAK-then-ACK path, and the expected flag words are computed
from those inputs.

// File: rtl/ep0_ctl_pkg.sv
`timescale 1ns/1ps
package ep0_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_DATA_OUT,
    ST_DATA_IN,
    ST_STATUS
  } stage_e;

  localparam int NFLAG   = 5;
  localparam int FL_BUF  = 0;
  localparam int FL_DONE = 1;
  localparam int FL_STG  = 2;
  localparam int FL_SBUF = 3;
  localparam int FL_ERR  = 4;

  localparam logic [1:0] MODE_HS_CTRL = 2'b01;
endpackage

// File: rtl/ep0_cen_reg.sv
`timescale 1ns/1ps
module ep0_cen_reg
  import ep0_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       setup_i,
  input  logic       wr_i,
  input  logic       wbit_i,
  input  logic [1:0] mode_i,
  output logic       cen_o,
  output logic       ack_o
);
  logic cen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cen_q <= 1'b0;
    else if (setup_i) cen_q <= 1'b0;
    else if (wr_i)    cen_q <= wbit_i;
  end

  assign cen_o = cen_q;
  assign ack_o = cen_q && (mode_i == MODE_HS_CTRL);

  // R4
  setup_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_i |=> !cen_q);

  // R3
  ack_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (cen_q && mode_i == 2'b01));
endmodule

// File: rtl/ep0_stage_fsm.sv
`timescale 1ns/1ps
module ep0_stage_fsm
  import ep0_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tok_setup_i,
  input  logic tok_in_i,
  input  logic tok_out_i,
  input  logic rd_dir_i,
  input  logic nodata_i,
  input  logic cen_i,
  input  logic ack_i,
  output logic done_o,
  output logic stg_chg_o
);
  stage_e stage_q, stage_d;
  logic   rd_q, nodata_q;
  logic   tok_stat, tok_data;

  // Status direction is the reverse of the data direction; no-data is IN.
  assign tok_stat = rd_q ? tok_out_i : tok_in_i;
  assign tok_data = rd_q ? tok_in_i  : tok_out_i;

  always_comb begin
    stage_d   = stage_q;
    done_o    = 1'b0;
    stg_chg_o = 1'b0;
    if (tok_setup_i) begin
      stage_d = ST_SETUP;
    end else begin
      case (stage_q)
        ST_SETUP: begin
          if (nodata_q) begin
            if (tok_stat) begin
              if (ack_i) begin done_o = 1'b1; stage_d = ST_IDLE; end
              else stage_d = ST_STATUS;
            end
          end else if (tok_data) begin
            stage_d = rd_q ? ST_DATA_IN : ST_DATA_OUT;
          end
        end
        ST_DATA_OUT, ST_DATA_IN: begin
          if (tok_stat) begin
            stg_chg_o = !cen_i;
            if (ack_i) begin done_o = 1'b1; stage_d = ST_IDLE; end
            else stage_d = ST_STATUS;
          end
        end
        ST_STATUS: begin
          if (tok_stat && ack_i) begin
            done_o  = 1'b1;
            stage_d = ST_IDLE;
          end
        end
        default: stage_d = stage_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= ST_IDLE;
      rd_q     <= 1'b0;
      nodata_q <= 1'b0;
    end else begin
      stage_q <= stage_d;
      if (tok_setup_i) begin
        rd_q     <= rd_dir_i & ~nodata_i;
        nodata_q <= nodata_i;
      end
    end
  end

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (stage_q == ST_IDLE));

  // R8
  stg_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stg_chg_o |-> (!cen_i && !ack_i));

  // R9
  nodata_stg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stg_chg_o |-> !nodata_q);

  // R12
  nak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == ST_STATUS && !tok_setup_i && !ack_i) |=> (stage_q == ST_STATUS));
endmodule

// File: rtl/ep0_irq_flags.sv
`timescale 1ns/1ps
module ep0_irq_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] hwclr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;

  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     flags_q[k] <= 1'b0;
      else if (set_i[k])              flags_q[k] <= 1'b1;
      else if (clr_i[k] || hwclr_i[k]) flags_q[k] <= 1'b0;
    end

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] |=> flags_q[k]);

    // R10
    hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hwclr_i[k] && !set_i[k]) |=> !flags_q[k]);
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/ep0_ctrl_xfer.sv
`timescale 1ns/1ps
module ep0_ctrl_xfer
  import ep0_ctl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok_setup_i,
  input  logic          tok_in_i,
  input  logic          tok_out_i,
  input  logic          setup_rd_i,
  input  logic          setup_nodata_i,
  input  logic          buf_rdy_i,
  input  logic          setup_buf_rdy_i,
  input  logic          xfer_err_i,
  input  logic [1:0]    rsp_mode_i,
  input  logic          cpu_we_i,
  input  logic          cpu_sel_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          status_ack_o,
  output logic          irq_o
);
  localparam int PADC = DW - 1;
  localparam int PADF = DW - NFLAG;

  logic             cen, ack, done, stg_chg;
  logic [NFLAG-1:0] set_v, clr_v, hwclr_v, flags;
  logic             unused_wr_hi;

  assign unused_wr_hi = ^cpu_wdata_i[DW-1:NFLAG];

  ep0_cen_reg u_cen (
    .clk     (clk),
    .rst_n   (rst_n),
    .setup_i (tok_setup_i),
    .wr_i    (cpu_we_i && !cpu_sel_i),
    .wbit_i  (cpu_wdata_i[0]),
    .mode_i  (rsp_mode_i),
    .cen_o   (cen),
    .ack_o   (ack)
  );

  ep0_stage_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tok_setup_i (tok_setup_i),
    .tok_in_i    (tok_in_i),
    .tok_out_i   (tok_out_i),
    .rd_dir_i    (setup_rd_i),
    .nodata_i    (setup_nodata_i),
    .cen_i       (cen),
    .ack_i       (ack),
    .done_o      (done),
    .stg_chg_o   (stg_chg)
  );

  always_comb begin
    set_v          = '0;
    set_v[FL_BUF]  = buf_rdy_i;
    set_v[FL_DONE] = done;
    set_v[FL_STG]  = stg_chg;
    set_v[FL_SBUF] = setup_buf_rdy_i;
    set_v[FL_ERR]  = xfer_err_i;
    hwclr_v         = '0;
    hwclr_v[FL_ERR] = tok_setup_i;
    clr_v = (cpu_we_i && cpu_sel_i) ? ~cpu_wdata_i[NFLAG-1:0] : '0;
  end

  ep0_irq_flags #(.N(NFLAG)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_v),
    .clr_i   (clr_v),
    .hwclr_i (hwclr_v),
    .flags_o (flags)
  );

  assign cpu_rdata_o  = cpu_sel_i ? {{PADF{1'b0}}, flags} : {{PADC{1'b0}}, cen};
  assign status_ack_o = ack;
  assign irq_o        = |flags;

  // R5
  rd_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata_o[DW-1:NFLAG] == '0);

  // R11
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !(|set_v)) |=> !irq_o);
endmodule

// File: tb/ep0_ctrl_xfer_bench.sv
`timescale 1ns/1ps
module ep0_ctrl_xfer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tok_setup = 0, tok_in = 0, tok_out = 0;
  logic       s_rd = 0, s_nod = 0, b_rdy = 0, sb_rdy = 0, err = 0;
  logic [1:0] mode = 2'b00;
  logic       we = 0, sel = 0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       sack, irq;
  int         n_chk = 0, n_fail = 0;
  bit         done_all = 0;

  always #2 clk = ~clk;

  ep0_ctrl_xfer u_ep0_ctrl_xfer (
    .clk(clk), .rst_n(rst_n),
    .tok_setup_i(tok_setup), .tok_in_i(tok_in), .tok_out_i(tok_out),
    .setup_rd_i(s_rd), .setup_nodata_i(s_nod),
    .buf_rdy_i(b_rdy), .setup_buf_rdy_i(sb_rdy), .xfer_err_i(err),
    .rsp_mode_i(mode), .cpu_we_i(we), .cpu_sel_i(sel), .cpu_wdata_i(wdata),
    .cpu_rdata_o(rdata), .status_ack_o(sack), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    tok_setup = 0; tok_in = 0; tok_out = 0; b_rdy = 0; sb_rdy = 0; err = 0; we = 0;
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    we = 1; sel = s; wdata = d; cyc();
  endtask

  task automatic rd(input logic s, output logic [7:0] v);
    sel = s; #1; v = rdata;
  endtask

  // kind: 0 control write, 1 control read, 2 no data
  task automatic setup(input int kind);
    s_rd = (kind == 1); s_nod = (kind == 2); tok_setup = 1; cyc();
  endtask

  task automatic stat_tok(input int kind);
    if (kind == 1) tok_out = 1; else tok_in = 1;
    cyc();
  endtask

  task automatic data_tok(input int kind);
    if (kind == 1) tok_in = 1; else tok_out = 1;
    cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_all) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rd(0, v); chk("R1 ctrl reset", v, 0);
    rd(1, v); chk("R1 flags reset", v, 0);
    chk("R1 irq reset", irq, 0);
    chk("R1 ack reset", sack, 0);
    rst_n = 1;
    cyc();

    // R2: only bit 0 stored
    wr(0, 8'hFF); rd(0, v); chk("R2 write ff", v, 8'h01);
    wr(0, 8'hFE); rd(0, v); chk("R2 write fe", v, 8'h00);

    // R3: every enable and mode
    for (int c = 0; c < 2; c++)
      for (int m = 0; m < 4; m++) begin
        mode = m[1:0]; wr(0, c[7:0]); #1;
        chk("R3 ack gate", sack, (c == 1 && m == 1) ? 1 : 0);
      end

    // R4: SETUP clears enable, wins over write
    wr(0, 8'h01); setup(0); rd(0, v); chk("R4 setup clear", v, 0);
    we = 1; sel = 0; wdata = 8'h01; tok_setup = 1; cyc();
    rd(0, v); chk("R4 setup beats write", v, 0);

    // R5, R11: buffer events and pad bits
    wr(1, 8'h00); rd(1, v); chk("R11 irq low", irq, 0);
    b_rdy = 1; cyc(); rd(1, v); chk("R5 buf flag", v, 8'h01);
    chk("R11 irq high", irq, 1);
    sb_rdy = 1; cyc(); rd(1, v); chk("R5 setup buf flag", v, 8'h09);
    wr(1, 8'hFF); rd(1, v); chk("R5 pad bits and R6 write-1 keeps", v, 8'h09);
    wr(1, 8'hF7); rd(1, v); chk("R6 clear bit3", v, 8'h01);
    we = 1; sel = 1; wdata = 8'h00; b_rdy = 1; cyc();
    rd(1, v); chk("R6 set beats clear", v, 8'h01);
    wr(1, 8'h00); rd(1, v); chk("R6 clear all", v, 0);
    chk("R11 irq cleared", irq, 0);

    // R10: error flag
    err = 1; cyc(); rd(1, v); chk("R10 err set", v, 8'h10);
    setup(0); rd(1, v); chk("R10 setup clears err", v, 0);
    err = 1; s_rd = 0; s_nod = 0; tok_setup = 1; cyc();
    rd(1, v); chk("R10 err beats setup", v, 8'h10);
    wr(1, 8'h00);

    // R7, R8, R9, R12: sweep transfer kind x enable x mode
    for (int k = 0; k < 3; k++)
      for (int c = 0; c < 2; c++)
        for (int m = 0; m < 4; m++) begin
          int exp_f;
          bit ok;
          mode = m[1:0];
          wr(1, 8'h00);
          setup(k);
          wr(0, c[7:0]);
          if (k != 2) begin data_tok(k); data_tok(k); end
          stat_tok(k);
          ok = (c == 1 && m == 1);
          exp_f = (ok ? 2 : 0) | ((k != 2 && c == 0) ? 4 : 0);
          rd(1, v);
          if (k == 2) chk("R9 nodata status", v, exp_f);
          else if (c == 1 && !ok) chk("R12 enabled but nak", v, exp_f);
          else chk("R7 R8 status token", v, exp_f);
          wr(1, 8'h00);
          if (ok) begin
            stat_tok(k); data_tok(k);
            rd(1, v); chk("R7 idle ignores tokens", v, 0);
          end else begin
            data_tok(k);
            rd(1, v); chk("R12 data token in status ignored", v, 0);
            mode = 2'b01; wr(0, 8'h01);
            stat_tok(k);
            rd(1, v); chk("R12 nak then ack", v, 2);
          end
        end

    done_all = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule